// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block gathers up to 32 level-sensitive interrupt lines from on-chip peripherals. It records them in a small set of memory-mapped registers, and it reports each enabled assertion to a processor by issuing one 32-bit memory write on a bus master port. Software sets a target word once. The upper 27 bits of that word give the address of the write, and the lowest 5 bits become the write data, which chooses the processor's interrupt bit. Every posted write carries the same address and data, whichever line caused it.

Software reaches the registers through a simple register slave port. The port takes byte enables on a big-endian word, and read data returns one cycle after the access. A pending word records every line that has been high, whether masked or not, and a read or a write of that word empties it. A request word records the enabled rising edges, and software clears it through a write-one-to-clear alias. A control bit that reports a bus error stops all posting. Posts that cannot go out at once, because the master port is waiting on ready, are counted and sent later, so lines that rise together are not lost. Fixed line numbers are assigned as follows: serial 5, parallel 7, network 8, disk controller 9, audio 13, the block itself 14, and keyboard/mouse 26.

Top module: `irq_post_hub`

## Requirements
- R1: Register words sit at byte offsets 0x00 request, 0x04 mask, 0x08 pending, 0x0C control, 0x10 target and 0x14 request-clear alias. After reset every register reads zero, except the target, which reads the parameter TGT_RESET (default 0). Unmapped offsets read zero, mst_req is low and mask_bad is low.
- R2: For each cycle in which line n is high, pending bit n is set, whatever the mask holds.
- R3: A read of the pending word returns its value and then clears it. A write to it clears it whatever the data or byte enables, and a line that is high in the same cycle sets its bit again.
- R4: A rising edge on line n while mask bit n is 1 sets request bit n and owes one post. A line held high produces exactly one post until it goes low and rises again. A rising edge on a masked line produces no post.
- R5: Each post drives mst_addr equal to the target word with bits [4:0] forced to zero, and mst_data equal to the target's bits [4:0] zero-extended.
- R6: Control bit 8 is the bus-error bit. While it is 1, rising edges post nothing, but they still set request bits. A control read returns only bit 8, and every other bit reads 0.
- R7: The legal mask bits are 5, 7, 8, 9, 13, 14, 16 through 21, and 26. A mask write whose resulting value has any other bit set, and is not all ones, sets the output mask_bad. mask_bad then stays 1 until reset.
- R8: Writes to offset 0x00 leave the request word unchanged. A write to offset 0x14 clears each request bit whose written data bit is 1 in an enabled byte lane.
- R9: Lines that rise in the same cycle, or while the master port is stalled, each produce one post. mst_req stays high, with mst_addr and mst_data stable, until mst_ready is sampled high.
- R10: Byte enable reg_be[i] selects the byte at address offset i, and that byte is carried on reg_wdata bits [31-8i:24-8i] (big-endian lanes). Bytes that are not enabled keep their old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Level interrupt lines |
| reg_sel | input | 1 | Register access strobe, one cycle per access |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset; bits [1:0] ignored |
| reg_be | input | 4 | Byte enables, big-endian lanes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after a read |
| mst_req | output | 1 | Post request |
| mst_ready | input | 1 | Fabric accepts the post this cycle |
| mst_addr | output | 32 | Post address |
| mst_data | output | 32 | Post data |
| mask_bad | output | 1 | Sticky illegal-mask flag |

## Verification
The bench holds a line high for many cycles and expects exactly one post. A design that posts on level instead of edge would flood the scoreboard with extra writes. It reads the pending word twice in a row, and also writes it with all-ones data. Either way, a design that failed to clear the word, or that merged the written data into it, would return stale bits. Five lines rise together while ready is held low, and exactly five posts must follow. A design that dropped simultaneous edges, or let addr/data move during a stall, would report a missing or wrong post. The bench also sets the bus-error bit and expects silence, checks the big-endian lane merge on the target word, and confirms that the mask flag exempts the all-ones pattern and stays set once raised.

// File: rtl/irq_post_pkg.sv
package irq_post_pkg;

  // Fixed line assignment
  localparam int unsigned LINE_SERIAL   = 5;
  localparam int unsigned LINE_PARALLEL = 7;
  localparam int unsigned LINE_NET      = 8;
  localparam int unsigned LINE_DISK     = 9;
  localparam int unsigned LINE_AUDIO    = 13;
  localparam int unsigned LINE_SELF     = 14;
  localparam int unsigned LINE_INPUT    = 26;

  // Word indices (byte offset / 4)
  localparam int unsigned WI_REQ    = 0;
  localparam int unsigned WI_MASK   = 1;
  localparam int unsigned WI_PEND   = 2;
  localparam int unsigned WI_CTRL   = 3;
  localparam int unsigned WI_TGT    = 4;
  localparam int unsigned WI_REQCLR = 5;

  localparam int unsigned CTRL_BERR_BIT = 8;
  localparam int unsigned SEL_BITS      = 5;

  function automatic logic [31:0] legal_mask();
    logic [31:0] m;
    m = '0;
    m[LINE_SERIAL]   = 1'b1;
    m[LINE_PARALLEL] = 1'b1;
    m[LINE_NET]      = 1'b1;
    m[LINE_DISK]     = 1'b1;
    m[LINE_AUDIO]    = 1'b1;
    m[LINE_SELF]     = 1'b1;
    m[LINE_INPUT]    = 1'b1;
    for (int i = 16; i <= 21; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Merge write data into an old word using big-endian byte lanes:
  // lane i (offset i) lives in bits [31-8i -: 8].
  function automatic logic [31:0] lane_merge(input logic [31:0] old_w,
                                             input logic [31:0] new_w,
                                             input logic [3:0]  be);
    logic [31:0] r;
    r = old_w;
    for (int i = 0; i < 4; i++)
      if (be[i]) r[31-8*i -: 8] = new_w[31-8*i -: 8];
    return r;
  endfunction

endpackage

// File: rtl/irq_post_edge.sv
module irq_post_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_d;

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= '0;
    else     lvl_d <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_d;
endmodule

// File: rtl/irq_post_regs.sv
module irq_post_regs
  import irq_post_pkg::*;
#(
  parameter int unsigned  ADDR_W    = 8,
  parameter logic [31:0]  TGT_RESET = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [31:0]       lvl_i,
  input  logic [31:0]       rise_i,
  output logic [31:0]       mask_q,
  output logic [31:0]       pend_q,
  output logic [31:0]       tgt_q,
  output logic              berr_q,
  output logic              mask_bad
);
  localparam int unsigned WIX_W = ADDR_W - 2;
  localparam logic [31:0] LEGAL = legal_mask();

  logic [WIX_W-1:0] widx;
  logic             wr_hit, rd_hit;
  logic [31:0]      req_q;
  logic [31:0]      mask_new, tgt_new, ctrl_new, clr_bits, be_bits;
  logic             mask_illegal;

  assign widx   = reg_addr[ADDR_W-1:2];
  assign wr_hit = reg_sel &  reg_wr;
  assign rd_hit = reg_sel & ~reg_wr;

  always_comb begin
    mask_new = lane_merge(mask_q, reg_wdata, reg_be);
    tgt_new  = lane_merge(tgt_q,  reg_wdata, reg_be);
    ctrl_new = lane_merge({23'b0, berr_q, 8'b0}, reg_wdata, reg_be);
    be_bits  = lane_merge(32'h0, 32'hFFFF_FFFF, reg_be);
    clr_bits = reg_wdata & be_bits;
    mask_illegal = ((mask_new & ~LEGAL) != 32'h0) && (mask_new != 32'hFFFF_FFFF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      pend_q   <= '0;
      req_q    <= '0;
      tgt_q    <= TGT_RESET;
      berr_q   <= 1'b0;
      mask_bad <= 1'b0;
    end else begin
      if (wr_hit && widx == WIX_W'(WI_MASK)) begin
        mask_q <= mask_new;
        if (mask_illegal) mask_bad <= 1'b1;
      end
      if (wr_hit && widx == WIX_W'(WI_TGT))  tgt_q  <= tgt_new;
      if (wr_hit && widx == WIX_W'(WI_CTRL)) berr_q <= ctrl_new[CTRL_BERR_BIT];

      if (reg_sel && widx == WIX_W'(WI_PEND)) pend_q <= lvl_i;
      else                                    pend_q <= pend_q | lvl_i;

      if (wr_hit && widx == WIX_W'(WI_REQCLR))
        req_q <= (req_q & ~clr_bits) | (rise_i & mask_q);
      else
        req_q <= req_q | (rise_i & mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (rd_hit) begin
      if      (widx == WIX_W'(WI_REQ))  reg_rdata <= req_q;
      else if (widx == WIX_W'(WI_MASK)) reg_rdata <= mask_q;
      else if (widx == WIX_W'(WI_PEND)) reg_rdata <= pend_q;
      else if (widx == WIX_W'(WI_CTRL)) reg_rdata <= {23'b0, berr_q, 8'b0};
      else if (widx == WIX_W'(WI_TGT))  reg_rdata <= tgt_q;
      else                              reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/irq_post_owed.sv
module irq_post_owed #(
  parameter int unsigned NSRC  = 32,
  parameter int unsigned CNT_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] fire_i,
  input  logic            take_i,
  output logic            any_o,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W:0] CMAX = {1'b0, {CNT_W{1'b1}}};

  logic [CNT_W:0] add, nxt;

  always_comb begin
    add = '0;
    for (int i = 0; i < NSRC; i++) add = add + {{CNT_W{1'b0}}, fire_i[i]};
    nxt = {1'b0, cnt_q} + add - {{CNT_W{1'b0}}, (take_i && any_o)};
    if (nxt > CMAX) nxt = CMAX;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt[CNT_W-1:0];
  end

  assign any_o = (cnt_q != '0);
endmodule

// File: rtl/irq_post_master.sv
module irq_post_master
  import irq_post_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        owed_i,
  output logic        take_o,
  input  logic [31:0] tgt_i,
  output logic        mst_req,
  input  logic        mst_ready,
  output logic [31:0] mst_addr,
  output logic [31:0] mst_data
);
  logic slot_free;

  assign slot_free = ~mst_req | mst_ready;
  assign take_o    = slot_free & owed_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      mst_req  <= 1'b0;
      mst_addr <= '0;
      mst_data <= '0;
    end else if (slot_free) begin
      mst_req <= owed_i;
      if (owed_i) begin
        mst_addr <= {tgt_i[31:SEL_BITS], {SEL_BITS{1'b0}}};
        mst_data <= {{(32-SEL_BITS){1'b0}}, tgt_i[SEL_BITS-1:0]};
      end
    end
  end
endmodule

// File: rtl/irq_post_hub.sv
module irq_post_hub
  import irq_post_pkg::*;
#(
  parameter int unsigned NSRC      = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned CNT_W     = 12,
  parameter logic [31:0] TGT_RESET = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_sel,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [3:0]        reg_be,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mst_req,
  input  logic              mst_ready,
  output logic [31:0]       mst_addr,
  output logic [31:0]       mst_data,
  output logic              mask_bad
);
  logic [31:0] lvl32, rise32, fire32;
  logic [31:0] mask_q, pend_q, tgt_q;
  logic        berr_q, owed_any, take;
  logic [CNT_W-1:0] owed_cnt;

  always_comb begin
    lvl32 = '0;
    lvl32[NSRC-1:0] = src_i;
  end

  irq_post_edge #(.W(32)) u_edge (
    .clk(clk), .rst(rst), .lvl_i(lvl32), .rise_o(rise32)
  );

  irq_post_regs #(.ADDR_W(ADDR_W), .TGT_RESET(TGT_RESET)) u_regs (
    .clk(clk), .rst(rst),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_i(lvl32), .rise_i(rise32),
    .mask_q(mask_q), .pend_q(pend_q), .tgt_q(tgt_q),
    .berr_q(berr_q), .mask_bad(mask_bad)
  );

  assign fire32 = rise32 & mask_q & {32{~berr_q}};

  irq_post_owed #(.NSRC(32), .CNT_W(CNT_W)) u_owed (
    .clk(clk), .rst(rst), .fire_i(fire32), .take_i(take),
    .any_o(owed_any), .cnt_q(owed_cnt)
  );

  irq_post_master u_mst (
    .clk(clk), .rst(rst), .owed_i(owed_any), .take_o(take),
    .tgt_i(tgt_q), .mst_req(mst_req), .mst_ready(mst_ready),
    .mst_addr(mst_addr), .mst_data(mst_data)
  );
endmodule

// File: rtl/irq_post_hub_chk.sv
module irq_post_hub_chk #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 12
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_i,
  input logic              reg_sel,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              mst_req,
  input logic              mst_ready,
  input logic [31:0]       mst_addr,
  input logic [31:0]       mst_data,
  input logic              mask_bad,
  input logic [31:0]       pend_q,
  input logic [CNT_W-1:0]  owed_cnt
);
  logic [31:0] lvl32;
  always_comb begin
    lvl32 = '0;
    lvl32[NSRC-1:0] = src_i;
  end

  p_pend_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (lvl32 != 32'h0) |=> ((pend_q & $past(lvl32)) == $past(lvl32)));

  p_addr_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    mst_req |-> (mst_addr[4:0] == 5'h0 && mst_data[31:5] == 27'h0));

  p_ctrl_read_r6: assert property (@(posedge clk) disable iff (rst)
    (reg_sel && !reg_wr && reg_addr[ADDR_W-1:2] == (ADDR_W-2)'(3))
      |=> ((reg_rdata & ~32'h0000_0100) == 32'h0));

  p_mask_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    mask_bad |=> mask_bad);

  p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (mst_req && !mst_ready) |=> (mst_req && $stable(mst_addr) && $stable(mst_data)));

  p_owed_step_r9: assert property (@(posedge clk) disable iff (rst)
    (owed_cnt < $past(owed_cnt)) |-> (owed_cnt == $past(owed_cnt) - 1'b1));
endmodule

bind irq_post_hub irq_post_hub_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .reg_sel(reg_sel), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .mst_req(mst_req),
  .mst_ready(mst_ready), .mst_addr(mst_addr), .mst_data(mst_data),
  .mask_bad(mask_bad), .pend_q(pend_q), .owed_cnt(owed_cnt)
);

// File: tb/irq_post_hub_tb.sv
module irq_post_hub_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src = '0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mst_req, mst_ready, mask_bad;
  logic [31:0] mst_addr, mst_data;

  int checks = 0, errors = 0;
  int cyc = 0;
  bit stall = 1'b0;
  bit done = 1'b0;
  logic [63:0] exp_q[$];

  always #5 clk = ~clk;

  irq_post_hub u_dut (
    .clk(clk), .rst(rst), .src_i(src), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mst_req(mst_req), .mst_ready(mst_ready),
    .mst_addr(mst_addr), .mst_data(mst_data), .mask_bad(mask_bad)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Ready driver and scoreboard monitor, in one process so order is fixed.
  always @(negedge clk) begin
    cyc++;
    mst_ready = !stall && (cyc % 3 != 0);
    if (!rst && mst_req && mst_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4: actual unexpected post %h/%h expected none", mst_addr, mst_data);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        if ({mst_addr, mst_data} !== e) begin
          errors++;
          $display("FAIL R5: actual %h expected %h", {mst_addr, mst_data}, e);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_sel = 1'b0;
    d = reg_rdata;
  endtask

  task automatic expect_post(input logic [31:0] tgt);
    exp_q.push_back({tgt & 32'hFFFF_FFE0, tgt & 32'h1F});
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(req, 32'(exp_q.size()), 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] tgt;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(8'h00, v); chk("R1 req", v, 32'h0);
    rd(8'h04, v); chk("R1 mask", v, 32'h0);
    rd(8'h08, v); chk("R1 pend", v, 32'h0);
    rd(8'h0C, v); chk("R1 ctrl", v, 32'h0);
    rd(8'h10, v); chk("R1 tgt", v, 32'h0);
    rd(8'h1C, v); chk("R1 unmapped", v, 32'h0);
    chk("R1 mst_req", {31'b0, mst_req}, 32'h0);
    chk("R1 mask_bad", {31'b0, mask_bad}, 32'h0);

    tgt = 32'h1234_5667;
    wr(8'h10, tgt, 4'hF);
    wr(8'h04, 32'h0000_0120, 4'hF);   // bits 5 and 8, legal
    chk("R7 legal mask", {31'b0, mask_bad}, 32'h0);

    // R2 unmasked line sets pending, no post
    @(negedge clk); src[7] = 1'b1;
    repeat (2) @(negedge clk); src[7] = 1'b0;
    rd(8'h08, v); chk("R2 pend unmasked", v, 32'h80);
    rd(8'h08, v); chk("R3 read clears", v, 32'h0);
    rd(8'h00, v); chk("R4 masked no req", v, 32'h0);

    // R3 write clears regardless of data
    @(negedge clk); src[9] = 1'b1;
    @(negedge clk); src[9] = 1'b0;
    wr(8'h08, 32'hFFFF_FFFF, 4'hF);
    rd(8'h08, v); chk("R3 write clears", v, 32'h0);

    // R4 held line posts once
    expect_post(tgt);
    @(negedge clk); src[5] = 1'b1;
    repeat (20) @(negedge clk);
    rd(8'h00, v); chk("R4 req set", v, 32'h20);
    src[5] = 1'b0;
    drain("R4 one post");

    // R8 request write ignored, alias clears
    wr(8'h00, 32'hFFFF_FFFF, 4'hF);
    rd(8'h00, v); chk("R8 ro ignored", v, 32'h20);
    wr(8'h14, 32'h0000_0020, 4'hF);
    rd(8'h00, v); chk("R8 w1c", v, 32'h0);

    // R6 bus error suppresses posting
    wr(8'h0C, 32'hFFFF_FFFF, 4'hF);
    rd(8'h0C, v); chk("R6 ctrl read", v, 32'h100);
    @(negedge clk); src[8] = 1'b1;
    repeat (3) @(negedge clk); src[8] = 1'b0;
    repeat (10) @(negedge clk);
    rd(8'h00, v); chk("R6 req still set", v, 32'h100);
    wr(8'h0C, 32'h0, 4'hF);
    wr(8'h14, 32'hFFFF_FFFF, 4'hF);

    // R9 simultaneous edges under stall
    wr(8'h04, 32'hFFFF_FFFF, 4'hF);
    chk("R7 all ones exempt", {31'b0, mask_bad}, 32'h0);
    stall = 1'b1;
    for (int i = 0; i < 5; i++) expect_post(tgt);
    @(negedge clk); src = 32'h0000_23A0;   // lines 5,7,8,9,13
    repeat (10) @(negedge clk);
    src = '0;
    stall = 1'b0;
    drain("R9 five posts");

    // R10 big-endian lane merge
    wr(8'h10, 32'hAB00_0000, 4'b0001);
    rd(8'h10, v); chk("R10 lane0", v, 32'hAB34_5667);
    wr(8'h10, 32'h0000_00C3, 4'b1000);
    rd(8'h10, v); chk("R10 lane3", v, 32'hAB34_56C3);
    tgt = 32'hAB34_56C3;
    expect_post(tgt);
    @(negedge clk); src[26] = 1'b1;
    @(negedge clk); src[26] = 1'b0;
    drain("R5 new target");

    // R7 sticky illegal mask
    wr(8'h04, 32'h0000_0001, 4'hF);
    chk("R7 illegal", {31'b0, mask_bad}, 32'h1);
    wr(8'h04, 32'h0000_0020, 4'hF);
    chk("R7 sticky", {31'b0, mask_bad}, 32'h1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule